// File: doc/BRIEF.md
# Gated Divide-by-2/4/8 Clock Generator

This block takes one input clock and produces three clocks at one half, one quarter and one eighth of its frequency. All three come from a single counter that runs on one internal clock. Because of that, every rising edge of a slower output falls on a rising edge of each faster output. Integrators use it to derive a family of phase-aligned clocks from one source.

A common enable gates the internal clock. The enable is captured by a flip-flop clocked on the falling edge of the input clock, and the gate is an AND of that flop with the input clock. The internal clock can therefore only be switched on or off while the input clock is low, so it never produces a shortened high pulse that could upset the counter. The enable flop is not cleared by the master reset and keeps sampling during reset.

An asynchronous, active-low master reset clears the counter so that all outputs are low. Several instances that share the input clock and the reset start from the same phase after release. The counter counts down from zero, so the first counted edge after reset drives all three outputs high together.

Top module: `clkdiv_gen`

## Requirements
- R1: While the captured enable is 1, `div2_o` changes level at every rising edge of `clk_i`.
- R2: Each enabled rising edge advances a 3-bit down counter whose bits 0, 1 and 2 drive `div2_o`, `div4_o` and `div8_o`. Over any run of enabled edges, `div4_o` toggles half as often as `div2_o`, and `div8_o` toggles a quarter as often.
- R3: Every rising edge of `div8_o` coincides with a rising edge of `div4_o`, and every rising edge of `div4_o` coincides with a rising edge of `div2_o`.
- R4: `en_i` is captured only at falling edges of `clk_i`. A change of `en_i` after a falling edge has no effect on the next rising edge. A change during the high phase governs the following rising edge.
- R5: The internal gated clock changes level only while `clk_i` is low or at a rising edge of `clk_i`. Consecutive transitions of `div2_o` occur at rising edges of `clk_i` and are at least one full input period apart.
- R6: While the captured enable is 0, all three outputs hold their levels.
- R7: When the enable is captured as 1 again, counting continues from the held state. The first counted edge gives the held 3-bit state minus one, modulo 8.
- R8: `rst_ni` low forces all outputs low at once, without waiting for a clock edge, and holds them low.
- R9: The first counted edge after reset release drives `div2_o`, `div4_o` and `div8_o` high at the same edge (state 7).
- R10: With the enable held at 1, each output is high for exactly half of its period. For example, `div8_o` is high on 8 of any 16 consecutive rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| en_i | input | 1 | Common enable, sampled on falling edge of clk_i |
| div2_o | output | 1 | Input clock divided by 2 (counter bit 0) |
| div4_o | output | 1 | Input clock divided by 4 (counter bit 1) |
| div8_o | output | 1 | Input clock divided by 8 (counter bit 2) |

## Verification
On every cycle the assertions check the following:
- `div2_o` toggles whenever the captured enable is high, and all outputs hold whenever it is low.
- Slower rising edges always coincide with faster ones.
- The gated clock only rises with the input clock and the captured enable only moves while the input clock is low.
- Outputs are low under reset.

Some behaviours only the bench scenarios can show:
- Exactly which edge a given enable change takes effect on.
- Resumption from a held state.
- The high state on the first edge after release.
- The exact 1:1/2:1/4 toggle ratios and the 50% duty over a long randomly gated run.

Those scenarios compare against an edge-count model.

// File: rtl/clkdiv_gen_pkg.sv
`timescale 1ns/1ps
package clkdiv_gen_pkg;
  localparam int unsigned DIV_STAGES = 3;
  typedef logic [DIV_STAGES-1:0] div_vec_t;
endpackage

// File: rtl/clkdiv_en_gate.sv
`timescale 1ns/1ps
// Falling-edge enable capture plus AND gate: gclk_o only switches while clk_i is low.
module clkdiv_en_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic en_q_o,
  output logic gclk_o
);
  logic en_q;

  always_ff @(negedge clk_i) en_q <= en_i;

  assign en_q_o = en_q;
  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/clkdiv_chain.sv
`timescale 1ns/1ps
// Synchronous down counter: each stage flips when all lower stages are zero.
module clkdiv_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [STAGES-1:0] div_o
);
  localparam int unsigned BW = STAGES + 1;

  logic [STAGES-1:0] cnt_q;
  logic [BW-1:0]     borrow;

  assign borrow[0] = 1'b1;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    assign borrow[k+1] = borrow[k] & ~cnt_q[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[k] <= 1'b0;
      else         cnt_q[k] <= cnt_q[k] ^ borrow[k];
    end
  end

  assign div_o = cnt_q;
endmodule

// File: rtl/clkdiv_gen.sv
`timescale 1ns/1ps
module clkdiv_gen
  import clkdiv_gen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic div2_o,
  output logic div4_o,
  output logic div8_o
);
  logic     en_q;
  logic     gclk;
  div_vec_t div_vec;

  clkdiv_en_gate u_gate (
    .clk_i  (clk_i),
    .en_i   (en_i),
    .en_q_o (en_q),
    .gclk_o (gclk)
  );

  clkdiv_chain #(.STAGES(DIV_STAGES)) u_chain (
    .clk_i  (gclk),
    .rst_ni (rst_ni),
    .div_o  (div_vec)
  );

  assign div2_o = div_vec[0];
  assign div4_o = div_vec[1];
  assign div8_o = div_vec[2];
endmodule

// File: rtl/clkdiv_gen_chk.sv
`timescale 1ns/1ps
module clkdiv_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_q_i,
  input logic       gclk_i,
  input logic [2:0] div_i
);
  AST_DIV2_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q_i |=> (div_i[0] != $past(div_i[0]))) else $error("div2 did not toggle"); // R1

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q_i |=> $stable(div_i)) else $error("outputs moved while gated"); // R6

  AST_ALIGN_DIV4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_i[1]) |-> $rose(div_i[0])) else $error("div4 rise unaligned"); // R3

  AST_ALIGN_DIV8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_i[2]) |-> $rose(div_i[1])) else $error("div8 rise unaligned"); // R3

  always @(posedge gclk_i) begin
    AST_GCLK_RISE: assert (clk_i) else $error("gated clock rose without clk"); // R5
  end

  always @(en_q_i) begin
    AST_GATE_LOW: assert (!clk_i) else $error("gate changed in high phase"); // R5
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_LOW: assert (div_i == 3'b000) else $error("outputs not low in reset"); // R8
    end
  end
endmodule

bind clkdiv_gen clkdiv_gen_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_q_i (en_q),
  .gclk_i (gclk),
  .div_i  (div_vec)
);

// File: tb/clkdiv_gen_bench.sv
`timescale 1ns/1ps
module clkdiv_gen_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic en_i = 1'b1;
  logic div2_o, div4_o, div8_o;

  int n_chk = 0;
  int n_err = 0;
  bit mon_on = 0;

  // edge-count model
  logic m_en = 1'b0;
  int   n_edges = 0;
  int   t2 = 0, t4 = 0, t8 = 0;
  realtime last2 = -1.0;

  always #2 clk_i = ~clk_i;

  clkdiv_gen u_clkdiv_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .div2_o (div2_o),
    .div4_o (div4_o),
    .div8_o (div8_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int outs();
    return {29'd0, div8_o, div4_o, div2_o};
  endfunction

  function automatic int exp_state(input int n);
    return (8 - (n % 8)) % 8;
  endfunction

  always @(negedge clk_i) m_en <= en_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   n_edges <= 0;
    else if (m_en) n_edges <= n_edges + 1;
  end

  // per-cycle model comparison: R1 R2 R3 R10
  always @(posedge clk_i) begin
    #1;
    if (mon_on && rst_ni) chk("R1 R2 R3 R10 model", outs(), exp_state(n_edges));
  end

  always @(negedge rst_ni) last2 = -1.0;

  // R5: div2 transitions only at rising clk edges, at least one period apart
  always @(div2_o) begin
    if (mon_on && rst_ni) begin
      t2++;
      chk("R5 div2 edge in high phase", int'(clk_i), 1);
      if (last2 >= 0.0) chk("R5 no runt", int'(($realtime - last2) > 3.999), 1);
      last2 = $realtime;
    end
  end

  always @(div4_o) if (mon_on && rst_ni) t4++;
  always @(div8_o) if (mon_on && rst_ni) t8++;

  initial begin
    #400000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int h;
    int hi_cnt;
    int n0;
    #1 rst_ni = 1'b0;
    repeat (4) @(posedge clk_i);
    #1 chk("R8 reset state", outs(), 0);

    // R9: release in low phase, first edge -> 111
    @(negedge clk_i);
    #0.5 rst_ni = 1'b1;
    @(posedge clk_i);
    #1 chk("R9 all high first edge", outs(), 7);
    mon_on = 1;

    // R10: duty of div8 over 16 edges
    hi_cnt = 0;
    repeat (16) begin
      @(posedge clk_i);
      #1 if (div8_o) hi_cnt++;
    end
    chk("R10 div8 duty", hi_cnt, 8);

    // R4: change after falling edge does not affect next rising edge
    @(negedge clk_i);
    #0.5 en_i = 1'b0;
    h = outs();
    @(posedge clk_i);
    #1 chk("R4 late disable still counts", outs(), (h + 7) % 8);

    // R6: held while disabled
    h = outs();
    repeat (8) begin
      @(posedge clk_i);
      #1 chk("R6 hold", outs(), h);
    end

    // R4 + R7: enable in high phase takes effect at next rising edge, resumes
    @(posedge clk_i);
    #0.5 en_i = 1'b1;
    @(posedge clk_i);
    #1 chk("R7 resume from held state", outs(), (h + 7) % 8);

    // random gating: R5 and ratio R2
    t2 = 0; t4 = 0; t8 = 0;
    n0 = n_edges;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk_i);
      #(0.5 + 1.0 * $urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) en_i = ~en_i;
    end
    @(posedge clk_i);
    #1.5;
    chk("R2 div2 toggles", t2, n_edges - n0);
    chk("R2 div4 toggles", t4, (n_edges + 1) / 2 - (n0 + 1) / 2);
    chk("R2 div8 toggles", t8, (n_edges + 3) / 4 - (n0 + 3) / 4);

    // R8: async reset in high phase
    en_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #0.5 rst_ni = 1'b0;
    #0.2 chk("R8 async clear", outs(), 0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    #0.5 rst_ni = 1'b1;
    @(posedge clk_i);
    #1 chk("R9 all high after second release", outs(), 7);
    repeat (4) @(posedge clk_i);
    #2;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule